// File: doc/BRIEF.md
# Predicated Vector Element Step Iterator

This block computes the next position of a vector loop that walks elements and, inside each element, sub-elements. Two identical iterators sit side by side: one advances the source element index and source sub-index, the other the destination pair. Each takes the current position, the vector length, the sub-vector length field, a loop-order bit and a predicate mask, and on a step strobe it registers the next position and a flag saying whether the step wrapped past the final position.

The loop-order bit picks which index is the inner loop. Cleared, the sub-index runs inside each element. Set, the element index runs inside each sub-index. When predicate skipping is enabled, an element advance does not just add one. It jumps straight to the next element position above the current one whose mask bit is set, which can be several positions in one strobe. A separate output reports, one cycle after the inputs are applied, that either the source or the destination position is the very last one of the loop.

Top module: `vec_step_iter`

## Requirements
- R1: After a synchronous reset, every registered output (both step values, both sub-index values, both end flags and the finish flag) is zero.
- R2: With the order bit clear and the current sub-index not equal to the sub-vector length field, a strobe increments the sub-index by one, keeps the step unchanged and clears the end flag.
- R3: With the order bit clear, the sub-index equal to the sub-vector length field and the step below vector length minus one, a strobe moves the step forward, zeroes the sub-index and clears the end flag.
- R4: With the order bit clear, the sub-index at its end and the step equal to vector length minus one, a strobe sets the end flag and zeroes both step and sub-index.
- R5: With the order bit set, a strobe with the step below its end moves only the step forward. With the step at vector length minus one and the sub-index not at its end, it zeroes the step and increments the sub-index.
- R6: With the order bit set and both step and sub-index at their ends, a strobe sets the end flag and leaves step and sub-index at those end values.
- R7: With skipping enabled, a step advance lands on the lowest index i above the current step with mask bit i set (bit 0 is position 0) and i at most vector length minus one. Mask bits at or beyond the vector length have no effect.
- R8: With skipping enabled and no such set bit, the advance runs off the end. With the order bit clear, the end flag is set and step and sub-index become zero. With it set, the step wraps to zero and the sub-index increments, or, if the sub-index was already at its end, the end flag is set and the step becomes vector length minus one.
- R9: With skipping disabled, the mask has no effect and a step advance always adds one.
- R10: A strobe whose current step exceeds vector length minus one, or whose sub-index exceeds the sub-vector length field, leaves that iterator's outputs unchanged.
- R11: With the strobe low, no step, sub-index or end-flag output changes.
- R12: The finish output, one cycle after its inputs, is 1 exactly when the source step equals vector length minus one with its sub-index equal to the field, or the destination step and sub-index are both at their ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Step strobe, shared by both iterators |
| vlen | input | 7 | Vector length, 1 to 64 |
| sublen | input | 2 | Sub-vector length field; sub-index runs 0 to this value |
| src_order | input | 1 | Source loop order: 1 makes the element step the inner loop |
| dst_order | input | 1 | Destination loop order, same encoding |
| src_skip | input | 1 | Source predicate skipping enable |
| dst_skip | input | 1 | Destination predicate skipping enable |
| src_mask | input | 64 | Source predicate, bit i for element i |
| dst_mask | input | 64 | Destination predicate, bit i for element i |
| src_pos | input | 6 | Current source step |
| src_sub | input | 2 | Current source sub-index |
| dst_pos | input | 6 | Current destination step |
| dst_sub | input | 2 | Current destination sub-index |
| src_pos_nx | output | 6 | Registered next source step |
| src_sub_nx | output | 2 | Registered next source sub-index |
| src_wrap | output | 1 | Registered source end flag |
| dst_pos_nx | output | 6 | Registered next destination step |
| dst_sub_nx | output | 2 | Registered next destination sub-index |
| dst_wrap | output | 1 | Registered destination end flag |
| loop_fin | output | 1 | Registered: either side at its final position |

## Verification
Every cycle, the assertions check that outputs hold with no strobe or with an out-of-range position, that the inner sub-index increments alone in the default order, that a plain advance adds exactly one, that any advanced step stays below the vector length, that a skipping advance lands on a set mask bit, and that both ends reached in the swapped order raise the end flag. Only the bench scenarios show the exact landing point of a multi-position jump, that mask bits beyond the vector length are ignored, the three ways a search can run off the end, the extremes of a one-element and a 64-element loop, and the finish output.

// File: rtl/vstep_pkg.sv
package vstep_pkg;
  localparam int VL_MAX = 64;
  localparam int SUB_W  = 2;
  localparam int STEP_W = $clog2(VL_MAX);
  localparam int LEN_W  = STEP_W + 1;

  typedef struct packed {
    logic [STEP_W-1:0] pos;
    logic [SUB_W-1:0]  sub;
    logic              wrap;
  } vstep_t;
endpackage

// File: rtl/vstep_nextbit.sv
module vstep_nextbit #(
  parameter int VL_MAX = vstep_pkg::VL_MAX,
  localparam int SW = $clog2(VL_MAX),
  localparam int LW = SW + 1
) (
  input  logic [VL_MAX-1:0] mask,
  input  logic [SW-1:0]     from,
  input  logic [LW-1:0]     vlen,
  output logic              hit,
  output logic [SW-1:0]     idx
);
  // Lowest set mask bit strictly above 'from' and below 'vlen'.
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = VL_MAX - 1; i >= 0; i--) begin
      if (mask[i] && (LW'(i) > {1'b0, from}) && (LW'(i) < vlen)) begin
        hit = 1'b1;
        idx = SW'(i);
      end
    end
  end
endmodule

// File: rtl/vstep_core.sv
module vstep_core
  import vstep_pkg::*;
#(
  parameter int VL_MAX = vstep_pkg::VL_MAX,
  localparam int SW = $clog2(VL_MAX),
  localparam int LW = SW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_en,
  input  logic [LW-1:0]     vlen,
  input  logic [SUB_W-1:0]  sublen,
  input  logic              order,
  input  logic              skip,
  input  logic [VL_MAX-1:0] mask,
  input  logic [SW-1:0]     pos_i,
  input  logic [SUB_W-1:0]  sub_i,
  output logic [SW-1:0]     pos_q,
  output logic [SUB_W-1:0]  sub_q,
  output logic              wrap_q
);
  logic [LW-1:0]    last;
  logic             pos_end, sub_end, in_ok;
  logic             found, hit;
  logic [SW-1:0]    found_idx, tgt;
  logic [SW-1:0]    n_pos;
  logic [SUB_W-1:0] n_sub;
  logic             n_wrap;

  assign last    = vlen - LW'(1);
  assign pos_end = ({1'b0, pos_i} == last);
  assign sub_end = (sub_i == sublen);
  assign in_ok   = ({1'b0, pos_i} <= last) && (sub_i <= sublen);

  vstep_nextbit #(.VL_MAX(VL_MAX)) u_find (
    .mask (mask),
    .from (pos_i),
    .vlen (vlen),
    .hit  (found),
    .idx  (found_idx)
  );

  assign hit = !skip || found;
  assign tgt = skip ? found_idx : pos_i + SW'(1);

  always_comb begin
    n_pos  = pos_i;
    n_sub  = sub_i;
    n_wrap = 1'b0;
    if (!order) begin
      if (!sub_end) begin
        n_sub = sub_i + SUB_W'(1);
      end else if (pos_end || !hit) begin
        n_pos  = '0;
        n_sub  = '0;
        n_wrap = 1'b1;
      end else begin
        n_pos = tgt;
        n_sub = '0;
      end
    end else begin
      if (pos_end) begin
        if (sub_end) n_wrap = 1'b1;
        else begin
          n_pos = '0;
          n_sub = sub_i + SUB_W'(1);
        end
      end else if (hit) begin
        n_pos = tgt;
      end else if (sub_end) begin
        n_pos  = last[SW-1:0];
        n_wrap = 1'b1;
      end else begin
        n_pos = '0;
        n_sub = sub_i + SUB_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q  <= '0;
      sub_q  <= '0;
      wrap_q <= 1'b0;
    end else if (step_en && in_ok) begin
      pos_q  <= n_pos;
      sub_q  <= n_sub;
      wrap_q <= n_wrap;
    end
  end

  AST_HOLD_BAD_INPUT: assert property (@(posedge clk) disable iff (rst)
    (step_en && (({1'b0, pos_i} >= vlen) || (sub_i > sublen)))
      |=> ($stable(pos_q) && $stable(sub_q) && $stable(wrap_q))); // R10

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> ($stable(pos_q) && $stable(sub_q) && $stable(wrap_q))); // R11

  AST_INNER_SUB: assert property (@(posedge clk) disable iff (rst)
    (step_en && in_ok && !order && (sub_i != sublen))
      |=> (pos_q == $past(pos_i)) && (sub_q == $past(sub_i) + SUB_W'(1)) && !wrap_q); // R2

  AST_PLAIN_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (step_en && in_ok && !skip && !order && sub_end && !pos_end)
      |=> (pos_q == $past(pos_i) + SW'(1)) && (sub_q == '0)); // R3

  AST_SWAPPED_END: assert property (@(posedge clk) disable iff (rst)
    (step_en && in_ok && order && pos_end && sub_end) |=> wrap_q); // R6

  AST_STEP_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (step_en && in_ok) |=> ({1'b0, pos_q} < $past(vlen))); // R7

  AST_SKIP_LANDS_SET: assert property (@(posedge clk) disable iff (rst)
    (step_en && in_ok && skip && !order && sub_end)
      |=> (wrap_q || ((($past(mask) >> pos_q) & VL_MAX'(1)) != '0))); // R7
endmodule

// File: rtl/vec_step_iter.sv
module vec_step_iter
  import vstep_pkg::*;
#(
  parameter int VL_MAX = vstep_pkg::VL_MAX,
  localparam int SW = $clog2(VL_MAX),
  localparam int LW = SW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_en,
  input  logic [LW-1:0]     vlen,
  input  logic [SUB_W-1:0]  sublen,
  input  logic              src_order,
  input  logic              dst_order,
  input  logic              src_skip,
  input  logic              dst_skip,
  input  logic [VL_MAX-1:0] src_mask,
  input  logic [VL_MAX-1:0] dst_mask,
  input  logic [SW-1:0]     src_pos,
  input  logic [SUB_W-1:0]  src_sub,
  input  logic [SW-1:0]     dst_pos,
  input  logic [SUB_W-1:0]  dst_sub,
  output logic [SW-1:0]     src_pos_nx,
  output logic [SUB_W-1:0]  src_sub_nx,
  output logic              src_wrap,
  output logic [SW-1:0]     dst_pos_nx,
  output logic [SUB_W-1:0]  dst_sub_nx,
  output logic              dst_wrap,
  output logic              loop_fin
);
  localparam int NSIDE = 2;

  logic              order_a [NSIDE];
  logic              skip_a  [NSIDE];
  logic [VL_MAX-1:0] mask_a  [NSIDE];
  logic [SW-1:0]     pos_a   [NSIDE];
  logic [SUB_W-1:0]  sub_a   [NSIDE];
  logic [SW-1:0]     pos_o   [NSIDE];
  logic [SUB_W-1:0]  sub_o   [NSIDE];
  logic              wrap_o  [NSIDE];
  logic              at_last [NSIDE];

  assign order_a[0] = src_order; assign order_a[1] = dst_order;
  assign skip_a[0]  = src_skip;  assign skip_a[1]  = dst_skip;
  assign mask_a[0]  = src_mask;  assign mask_a[1]  = dst_mask;
  assign pos_a[0]   = src_pos;   assign pos_a[1]   = dst_pos;
  assign sub_a[0]   = src_sub;   assign sub_a[1]   = dst_sub;

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    vstep_core #(.VL_MAX(VL_MAX)) u_core (
      .clk     (clk),
      .rst     (rst),
      .step_en (step_en),
      .vlen    (vlen),
      .sublen  (sublen),
      .order   (order_a[g]),
      .skip    (skip_a[g]),
      .mask    (mask_a[g]),
      .pos_i   (pos_a[g]),
      .sub_i   (sub_a[g]),
      .pos_q   (pos_o[g]),
      .sub_q   (sub_o[g]),
      .wrap_q  (wrap_o[g])
    );
    assign at_last[g] = ({1'b0, pos_a[g]} == vlen - LW'(1)) && (sub_a[g] == sublen);
  end

  assign src_pos_nx = pos_o[0];
  assign src_sub_nx = sub_o[0];
  assign src_wrap   = wrap_o[0];
  assign dst_pos_nx = pos_o[1];
  assign dst_sub_nx = sub_o[1];
  assign dst_wrap   = wrap_o[1];

  always_ff @(posedge clk) begin
    if (rst) loop_fin <= 1'b0;
    else     loop_fin <= at_last[0] || at_last[1];
  end
endmodule

// File: tb/sim_vec_step_iter.sv
`timescale 1ns/1ps
module sim_vec_step_iter;
  logic clk = 0, rst = 1, step_en = 0;
  logic [6:0] vlen = 7'd8;
  logic [1:0] sublen = 0;
  logic src_order = 0, dst_order = 0, src_skip = 0, dst_skip = 0;
  logic [63:0] src_mask = 0, dst_mask = 0;
  logic [5:0] src_pos = 0, dst_pos = 0;
  logic [1:0] src_sub = 0, dst_sub = 0;
  logic [5:0] src_pos_nx, dst_pos_nx;
  logic [1:0] src_sub_nx, dst_sub_nx;
  logic src_wrap, dst_wrap, loop_fin;
  int n_run = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vec_step_iter u0 (.*);

  typedef struct packed {
    logic [6:0] vl; logic [1:0] sl; logic ord; logic skp; logic [63:0] msk;
    logic [5:0] pos; logic [1:0] sub;
    logic [5:0] e_pos; logic [1:0] e_sub; logic e_wrap;
  } vec_t;

  localparam int NV = 16;
  localparam logic [91:0] TBL [0:NV-1] = '{
    {7'd8, 2'd1, 1'b0, 1'b0, 64'h0, 6'd3, 2'd0, 6'd3, 2'd1, 1'b0},   // R2
    {7'd8, 2'd1, 1'b0, 1'b0, 64'h0, 6'd3, 2'd1, 6'd4, 2'd0, 1'b0},   // R3
    {7'd8, 2'd1, 1'b0, 1'b0, 64'h0, 6'd7, 2'd1, 6'd0, 2'd0, 1'b1},   // R4
    {7'd8, 2'd0, 1'b0, 1'b1, 64'hA0, 6'd2, 2'd0, 6'd5, 2'd0, 1'b0},  // R7
    {7'd8, 2'd0, 1'b0, 1'b1, 64'h01, 6'd2, 2'd0, 6'd0, 2'd0, 1'b1},  // R8
    {7'd6, 2'd0, 1'b0, 1'b1, 64'h80, 6'd1, 2'd0, 6'd0, 2'd0, 1'b1},  // R7 beyond vl
    {7'd8, 2'd2, 1'b1, 1'b0, 64'h0, 6'd3, 2'd1, 6'd4, 2'd1, 1'b0},   // R5
    {7'd8, 2'd2, 1'b1, 1'b0, 64'h0, 6'd7, 2'd1, 6'd0, 2'd2, 1'b0},   // R5
    {7'd8, 2'd2, 1'b1, 1'b0, 64'h0, 6'd7, 2'd2, 6'd7, 2'd2, 1'b1},   // R6
    {7'd16, 2'd1, 1'b1, 1'b1, 64'h1000, 6'd4, 2'd0, 6'd12, 2'd0, 1'b0}, // R7
    {7'd16, 2'd1, 1'b1, 1'b1, 64'h1, 6'd4, 2'd0, 6'd0, 2'd1, 1'b0},  // R8
    {7'd16, 2'd1, 1'b1, 1'b1, 64'h1, 6'd4, 2'd1, 6'd15, 2'd1, 1'b1}, // R8
    {7'd64, 2'd0, 1'b0, 1'b1, 64'h8000_0000_0000_0000, 6'd0, 2'd0, 6'd63, 2'd0, 1'b0}, // R7
    {7'd1, 2'd0, 1'b0, 1'b0, 64'h0, 6'd0, 2'd0, 6'd0, 2'd0, 1'b1},   // R4 vl=1
    {7'd1, 2'd1, 1'b1, 1'b0, 64'h0, 6'd0, 2'd0, 6'd0, 2'd1, 1'b0},   // R5 vl=1
    {7'd8, 2'd0, 1'b0, 1'b0, 64'h0, 6'd2, 2'd0, 6'd3, 2'd0, 1'b0}    // R9
  };

  task automatic check(string req, logic [8:0] got, logic [8:0] exp);
    n_run++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic drive(vec_t v, logic strobe);
    vlen = v.vl; sublen = v.sl;
    src_order = v.ord; dst_order = v.ord; src_skip = v.skp; dst_skip = v.skp;
    src_mask = v.msk; dst_mask = v.msk;
    src_pos = v.pos; dst_pos = v.pos; src_sub = v.sub; dst_sub = v.sub;
    step_en = strobe;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    vec_t v;
    logic [8:0] held;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    rst = 1; @(negedge clk); rst = 0;
    // R1: reset state (one cycle after reset drops, nothing strobed)
    check("R1", {src_pos_nx, src_sub_nx, src_wrap}, 9'd0);
    check("R1", {dst_pos_nx, dst_sub_nx, dst_wrap, loop_fin} >> 1, 9'd0);

    for (int i = 0; i < NV; i++) begin
      v = TBL[i];
      @(negedge clk); drive(v, 1'b1);
      @(negedge clk);
      check($sformatf("R2-9 vec%0d src", i), {src_pos_nx, src_sub_nx, src_wrap},
            {v.e_pos, v.e_sub, v.e_wrap});
      check($sformatf("R2-9 vec%0d dst", i), {dst_pos_nx, dst_sub_nx, dst_wrap},
            {v.e_pos, v.e_sub, v.e_wrap});
    end

    // R9: skipping disabled with a sparse mask still adds one
    v = TBL[15]; v.msk = 64'h80;
    @(negedge clk); drive(v, 1'b1); @(negedge clk);
    check("R9", {src_pos_nx, src_sub_nx, src_wrap}, {6'd3, 2'd0, 1'b0});

    // R10: out-of-range step, then out-of-range sub-index, hold the outputs
    held = {src_pos_nx, src_sub_nx, src_wrap};
    v = TBL[1]; v.pos = 6'd9;
    @(negedge clk); drive(v, 1'b1); @(negedge clk);
    check("R10 step", {src_pos_nx, src_sub_nx, src_wrap}, held);
    v = TBL[1]; v.sub = 2'd3;
    @(negedge clk); drive(v, 1'b1); @(negedge clk);
    check("R10 sub", {src_pos_nx, src_sub_nx, src_wrap}, held);

    // R11: strobe low, inputs that would otherwise change the outputs
    v = TBL[2];
    @(negedge clk); drive(v, 1'b0); @(negedge clk); @(negedge clk);
    check("R11", {dst_pos_nx, dst_sub_nx, dst_wrap}, held);

    // R12: finish flag
    v = TBL[0];
    @(negedge clk); drive(v, 1'b0);
    vlen = 7'd8; sublen = 2'd1;
    src_pos = 6'd7; src_sub = 2'd1; dst_pos = 6'd2; dst_sub = 2'd1;
    @(negedge clk);
    check("R12 src", {8'd0, loop_fin}, 9'd1);
    src_pos = 6'd7; src_sub = 2'd0; dst_pos = 6'd6; dst_sub = 2'd1;
    @(negedge clk);
    check("R12 none", {8'd0, loop_fin}, 9'd0);
    dst_pos = 6'd7;
    @(negedge clk);
    check("R12 dst", {8'd0, loop_fin}, 9'd1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule